// File: doc/BRIEF.md
# BCD Time-and-Date Counter with Alarm

This block is the counting core of a real-time clock. It holds the time of day (seconds, minutes, hours) and the date (day, month, two-digit year in the range 2000 to 2099) as packed BCD digits. It also keeps a three-bit weekday and flags leap years. Software-side logic can overwrite any of these words through load ports. The counters step forward once for each one-second enable pulse, under either a 24-hour or a 12-hour scale. A second pair of registers holds an alarm time and an alarm date. The alarm flag rises when the counters step onto that exact moment, and it stays set until a write-1-to-clear strobe removes it.

A small sequencer spreads each one-second update over four clock states, so no single cycle carries a long carry chain. The states are ST_IDLE, ST_TIME, ST_DATE and ST_CHECK. Transitions: ST_IDLE goes to ST_TIME when a tick arrives, otherwise it stays put. ST_TIME always goes to ST_DATE; this is where the time word advances and the end-of-day carry is captured. ST_DATE always goes to ST_CHECK; the date and weekday advance here only if the carry was captured. ST_CHECK always returns to ST_IDLE; the alarm comparison runs here. A tick that arrives while the sequencer is not in ST_IDLE is dropped. Crystal prescaling and frequency trimming are outside this block.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the time word, date word and weekday all read 0 and the alarm flag reads 0. The leap bit reads 1, because year 00 is a leap year.
- R2: The time word holds seconds ones in [3:0] and tens in [6:4], minutes ones in [11:8] and tens in [14:12], and hours in [21:16]. Each step counts in BCD: x9 becomes (x+1)0, and 59 becomes 00 with a carry into the next field.
- R3: With the scale bit at 0 (24-hour), the hours run 00 to 23. A step from 23:59:59 gives 00:00:00 and advances the date.
- R4: With the scale bit at 1 (12-hour), bit 21 is the PM flag, bit 20 is the hour tens digit and the hours run 12, 01 ... 11. A step from 11:59:59 AM gives 12:00:00 PM and leaves the date unchanged. A step from 11:59:59 PM gives 12:00:00 AM and advances the date. A step from 12:59:59 gives 01:00:00.
- R5: The date word holds day ones in [3:0] and tens in [5:4], month ones in [11:8] and tens in bit 12, and year ones in [19:16] and tens in [23:20]. April, June, September and November end after day 30; the other months except February end after day 31. At a month end the day returns to 01 and the month advances in BCD.
- R6: The leap bit is 1 when the two-digit year is divisible by 4. February ends after day 29 in a leap year and after day 28 otherwise.
- R7: A date advance from December 31 gives January 01 of the next year, and year 99 wraps to 00.
- R8: The weekday (0 = Sunday ... 6 = Saturday) advances by one at each date advance and is otherwise held. Saturday, or the reserved code 7, wraps to 0.
- R9: The alarm flag sets only in the update that follows a tick, and only when both the time word and the date word equal the alarm time and alarm date. A direct load of a matching value does not set it.
- R10: Holding the clear strobe at 1 for a cycle clears the flag at that edge. If the clear coincides with a new match in ST_CHECK, the flag stays set.
- R11: Every load takes effect at the next clock edge. Bits outside the digit fields are stored as 0; the time mask is 0x3F7F7F and the date mask is 0xFF1F3F.
- R12: Take a tick sampled at edge E0. The time word changes at edge E0+1, the date and weekday at edge E0+2, and the alarm flag at edge E0+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-second advance pulse |
| hr12_sel | input | 1 | 1 selects the 12-hour scale, 0 selects the 24-hour scale |
| time_ld | input | 1 | Load strobe for the time word |
| time_ld_val | input | 24 | Time value to load |
| date_ld | input | 1 | Load strobe for the date word |
| date_ld_val | input | 24 | Date value to load |
| dow_ld | input | 1 | Load strobe for the weekday |
| dow_ld_val | input | 3 | Weekday value to load |
| alm_time_ld | input | 1 | Load strobe for the alarm time |
| alm_time_val | input | 24 | Alarm time value |
| alm_date_ld | input | 1 | Load strobe for the alarm date |
| alm_date_val | input | 24 | Alarm date value |
| alm_clr | input | 1 | Write-1-to-clear strobe for the alarm flag |
| time_out | output | 24 | Current time word |
| date_out | output | 24 | Current date word |
| dow_out | output | 3 | Current weekday |
| leap_out | output | 1 | Leap-year indication for the current year |
| alm_flag | output | 1 | Alarm flag |

## Verification
The bench targets the rollover edges:
- Seconds into minutes, and 09 into 10 in the hour.
- Midnight in both scales, including the 11 AM and 11 PM crossings and 12 into 01. A design that confused these would either advance the date at noon or fail to advance it at midnight.
- The ends of 30-day and 31-day months, February in common and leap years, September into October, and December 31 of year 99. A wrong month-length table or a missing BCD adjustment shows up here as a day 31 in April, a day 29 in 2025, or a hex month such as 0A.
- Weekday wrap from Saturday.
- The alarm cases: a load of the alarm value that must not set the flag, a date mismatch, and a clear that lands on the same edge as a fresh match, where a clear-first design would lose the event.

The cycle of each update is checked directly, which catches any design that commits time and date in the wrong order.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int WORD_W = 24;
    localparam int DOW_W  = 3;
    localparam logic [WORD_W-1:0] TIME_MASK = 24'h3F7F7F;
    localparam logic [WORD_W-1:0] DATE_MASK = 24'hFF1F3F;
    localparam logic [DOW_W-1:0]  DOW_LAST  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TIME,
        ST_DATE,
        ST_CHECK
    } seq_state_t;

    // two BCD digits to binary (0..99)
    function automatic logic [6:0] bcd2bin(input logic [3:0] tens, input logic [3:0] ones);
        return (7'(tens) * 7'd10) + 7'(ones);
    endfunction

    // increment a two-digit BCD value (caller handles the top wrap)
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // leap test on a BCD year: divisible by 4
    function automatic logic leap_of(input logic [7:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [4:0] days_in(input logic [6:0] mon, input logic leap);
        case (mon)
            7'd2:                       return leap ? 5'd29 : 5'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_val,
    input  logic              step,
    input  logic              hr12,
    output logic [WORD_W-1:0] time_q,
    output logic              day_wrap
);

    logic [7:0] sec_inc, min_inc, h24_inc, h12_inc;
    logic       sec_wrap, min_wrap;
    logic [6:0] sec_nx, min_nx;
    logic [5:0] hr, hr_nx;
    logic [4:0] h12;
    logic       pm;

    assign sec_inc  = bcd_inc8({1'b0, time_q[6:0]});
    assign min_inc  = bcd_inc8({1'b0, time_q[14:8]});
    assign hr       = time_q[21:16];
    assign pm       = hr[5];
    assign h12      = hr[4:0];
    assign h24_inc  = bcd_inc8({2'b0, hr});
    assign h12_inc  = bcd_inc8({3'b0, h12});

    assign sec_wrap = (time_q[6:0]  == 7'h59);
    assign min_wrap = (time_q[14:8] == 7'h59);

    always_comb begin
        sec_nx = sec_wrap ? 7'h00 : sec_inc[6:0];
        min_nx = time_q[14:8];
        hr_nx  = hr;
        if (sec_wrap)
            min_nx = min_wrap ? 7'h00 : min_inc[6:0];
        if (sec_wrap && min_wrap) begin
            if (hr12) begin
                if (h12 == 5'h11)
                    hr_nx = {~pm, 5'h12};
                else if (h12 == 5'h12)
                    hr_nx = {pm, 5'h01};
                else
                    hr_nx = {pm, h12_inc[4:0]};
            end else begin
                hr_nx = (hr == 6'h23) ? 6'h00 : h24_inc[5:0];
            end
        end
    end

    assign day_wrap = sec_wrap && min_wrap &&
                      (hr12 ? (pm && (h12 == 5'h11)) : (hr == 6'h23));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            time_q <= '0;
        else if (ld)
            time_q <= ld_val & TIME_MASK;
        else if (step)
            time_q <= {2'b00, hr_nx, 1'b0, min_nx, 1'b0, sec_nx};
    end

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_val,
    input  logic              dow_ld,
    input  logic [DOW_W-1:0]  dow_val,
    input  logic              step,
    output logic [WORD_W-1:0] date_q,
    output logic [DOW_W-1:0]  dow_q,
    output logic              leap
);

    logic [5:0] day;
    logic [4:0] mon;
    logic [7:0] yr;
    logic [6:0] mon_b, day_b;
    logic [4:0] dlen;
    logic       month_end, year_end;
    logic [7:0] day_inc, mon_inc, yr_inc;
    logic [5:0] day_nx;
    logic [4:0] mon_nx;
    logic [7:0] yr_nx;

    assign day   = date_q[5:0];
    assign mon   = date_q[12:8];
    assign yr    = date_q[23:16];
    assign leap  = leap_of(yr);
    assign mon_b = bcd2bin({3'b0, mon[4]}, mon[3:0]);
    assign day_b = bcd2bin({2'b0, day[5:4]}, day[3:0]);
    assign dlen  = days_in(mon_b, leap);

    assign month_end = (day_b >= {2'b00, dlen});
    assign year_end  = month_end && (mon_b == 7'd12);

    assign day_inc = bcd_inc8({2'b0, day});
    assign mon_inc = bcd_inc8({3'b0, mon});
    assign yr_inc  = bcd_inc8(yr);

    always_comb begin
        day_nx = month_end ? 6'h01 : day_inc[5:0];
        mon_nx = mon;
        yr_nx  = yr;
        if (month_end)
            mon_nx = year_end ? 5'h01 : mon_inc[4:0];
        if (year_end)
            yr_nx = (yr == 8'h99) ? 8'h00 : yr_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            date_q <= '0;
        else if (ld)
            date_q <= ld_val & DATE_MASK;
        else if (step)
            date_q <= {yr_nx, 3'b000, mon_nx, 2'b00, day_nx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dow_q <= '0;
        else if (dow_ld)
            dow_q <= dow_val;
        else if (step)
            dow_q <= (dow_q >= DOW_LAST) ? '0 : dow_q + 1'b1;
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_ld,
    input  logic [WORD_W-1:0] at_val,
    input  logic              ad_ld,
    input  logic [WORD_W-1:0] ad_val,
    input  logic [WORD_W-1:0] cur_time,
    input  logic [WORD_W-1:0] cur_date,
    input  logic              eval,
    input  logic              clr,
    output logic              flag
);

    logic [WORD_W-1:0] at_q, ad_q;
    logic              hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            at_q <= '0;
            ad_q <= '0;
        end else begin
            if (at_ld) at_q <= at_val & TIME_MASK;
            if (ad_ld) ad_q <= ad_val & DATE_MASK;
        end
    end

    assign hit = (cur_time == at_q) && (cur_date == ad_q);

    // a fresh match outranks a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= (flag && !clr) || (eval && hit);
    end

endmodule

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       day_wrap,
    output logic       step_time,
    output logic       step_date,
    output logic       eval,
    output seq_state_t state_o
);

    seq_state_t st, st_nx;
    logic       carry_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  st_nx = tick ? ST_TIME : ST_IDLE;
            ST_TIME:  st_nx = ST_DATE;
            ST_DATE:  st_nx = ST_CHECK;
            ST_CHECK: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            carry_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_TIME)
                carry_q <= day_wrap;
        end
    end

    always_comb begin
        step_time = 1'b0;
        step_date = 1'b0;
        eval      = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_TIME:  step_time = 1'b1;
            ST_DATE:  step_date = carry_q;
            ST_CHECK: eval      = 1'b1;
        endcase
    end

    assign state_o = st;

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_bcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        hr12_sel,
    input  logic        time_ld,
    input  logic [23:0] time_ld_val,
    input  logic        date_ld,
    input  logic [23:0] date_ld_val,
    input  logic        dow_ld,
    input  logic [2:0]  dow_ld_val,
    input  logic        alm_time_ld,
    input  logic [23:0] alm_time_val,
    input  logic        alm_date_ld,
    input  logic [23:0] alm_date_val,
    input  logic        alm_clr,
    output logic [23:0] time_out,
    output logic [23:0] date_out,
    output logic [2:0]  dow_out,
    output logic        leap_out,
    output logic        alm_flag
);

    logic       step_time, step_date, eval, day_wrap;
    seq_state_t seq_st;

    rtc_tick_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .day_wrap  (day_wrap),
        .step_time (step_time),
        .step_date (step_date),
        .eval      (eval),
        .state_o   (seq_st)
    );

    rtc_time_cnt u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (time_ld),
        .ld_val   (time_ld_val),
        .step     (step_time),
        .hr12     (hr12_sel),
        .time_q   (time_out),
        .day_wrap (day_wrap)
    );

    rtc_date_cnt u_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (date_ld),
        .ld_val  (date_ld_val),
        .dow_ld  (dow_ld),
        .dow_val (dow_ld_val),
        .step    (step_date),
        .date_q  (date_out),
        .dow_q   (dow_out),
        .leap    (leap_out)
    );

    rtc_alarm_unit u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .at_ld    (alm_time_ld),
        .at_val   (alm_time_val),
        .ad_ld    (alm_date_ld),
        .ad_val   (alm_date_val),
        .cur_time (time_out),
        .cur_date (date_out),
        .eval     (eval),
        .clr      (alm_clr),
        .flag     (alm_flag)
    );

endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_bcd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        time_ld,
    input logic        dow_ld,
    input logic        alm_clr,
    input logic [23:0] time_q,
    input logic [2:0]  dow_q,
    input logic        alm_flag,
    input seq_state_t  st
);

    assert_time_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(time_q) |-> $past(time_ld || (st == ST_TIME)));

    assert_dow_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dow_q) |-> $past(dow_ld || (st == ST_DATE)));

    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(st == ST_CHECK));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_clr && (st != ST_CHECK)) |=> !alm_flag);

    assert_seq_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TIME) |=> (st == ST_DATE));

    assert_seq_check_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATE) |=> (st == ST_CHECK));

endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .time_ld  (time_ld),
    .dow_ld   (dow_ld),
    .alm_clr  (alm_clr),
    .time_q   (time_out),
    .dow_q    (dow_out),
    .alm_flag (alm_flag),
    .st       (seq_st)
);

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        hr12_sel = 1'b0;
    logic        time_ld = 1'b0;
    logic [23:0] time_ld_val = '0;
    logic        date_ld = 1'b0;
    logic [23:0] date_ld_val = '0;
    logic        dow_ld = 1'b0;
    logic [2:0]  dow_ld_val = '0;
    logic        alm_time_ld = 1'b0;
    logic [23:0] alm_time_val = '0;
    logic        alm_date_ld = 1'b0;
    logic [23:0] alm_date_val = '0;
    logic        alm_clr = 1'b0;
    logic [23:0] time_out, date_out;
    logic [2:0]  dow_out;
    logic        leap_out, alm_flag;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_core u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hr12_sel(hr12_sel),
        .time_ld(time_ld), .time_ld_val(time_ld_val),
        .date_ld(date_ld), .date_ld_val(date_ld_val),
        .dow_ld(dow_ld), .dow_ld_val(dow_ld_val),
        .alm_time_ld(alm_time_ld), .alm_time_val(alm_time_val),
        .alm_date_ld(alm_date_ld), .alm_date_val(alm_date_val),
        .alm_clr(alm_clr), .time_out(time_out), .date_out(date_out),
        .dow_out(dow_out), .leap_out(leap_out), .alm_flag(alm_flag)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_time(input logic [23:0] v);
        @(negedge clk); time_ld = 1'b1; time_ld_val = v;
        @(negedge clk); time_ld = 1'b0;
    endtask

    task automatic load_date(input logic [23:0] v);
        @(negedge clk); date_ld = 1'b1; date_ld_val = v;
        @(negedge clk); date_ld = 1'b0;
    endtask

    task automatic load_dow(input logic [2:0] v);
        @(negedge clk); dow_ld = 1'b1; dow_ld_val = v;
        @(negedge clk); dow_ld = 1'b0;
    endtask

    task automatic load_alarm(input logic [23:0] t, input logic [23:0] d);
        @(negedge clk); alm_time_ld = 1'b1; alm_time_val = t;
        alm_date_ld = 1'b1; alm_date_val = d;
        @(negedge clk); alm_time_ld = 1'b0; alm_date_ld = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); alm_clr = 1'b1;
        @(negedge clk); alm_clr = 1'b0;
    endtask

    // midnight step on a given date, returns after the update completes
    task automatic day_step(input logic [23:0] d);
        hr12_sel = 1'b0;
        load_date(d);
        load_time(24'h235959);
        tick_once();
    endtask

    task automatic t_reset();
        check("R1 time after reset", time_out, 24'h0);
        check("R1 date after reset", date_out, 24'h0);
        check("R1 weekday after reset", {21'b0, dow_out}, 24'h0);
        check("R1 flag after reset", {23'b0, alm_flag}, 24'h0);
        check("R1 leap after reset", {23'b0, leap_out}, 24'h1);
    endtask

    task automatic t_mask();
        load_time(24'hFFFFFF);
        check("R11 time mask", time_out, 24'h3F7F7F);
        load_date(24'hFFFFFF);
        check("R11 date mask", date_out, 24'hFF1F3F);
    endtask

    task automatic t_seconds();
        hr12_sel = 1'b0;
        load_date(24'h250110);
        load_time(24'h000009);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        check("R12 time held one edge after tick", time_out, 24'h000009);
        @(negedge clk);
        check("R2 09 to 10 seconds", time_out, 24'h000010);
        repeat (3) @(negedge clk);
        load_time(24'h000059); tick_once();
        check("R2 seconds into minute", time_out, 24'h000100);
        load_time(24'h005959); tick_once();
        check("R2 minutes into hour", time_out, 24'h010000);
        load_time(24'h095959); tick_once();
        check("R3 hour 09 to 10", time_out, 24'h100000);
        check("R3 no date step mid-day", date_out, 24'h250110);
    endtask

    task automatic t_midnight24();
        hr12_sel = 1'b0;
        load_date(24'h240131);
        load_dow(3'd6);
        load_time(24'h235959);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk);
        check("R3 midnight time", time_out, 24'h000000);
        check("R12 date held until third edge", date_out, 24'h240131);
        @(negedge clk);
        check("R5 Jan 31 to Feb 01", date_out, 24'h240201);
        check("R8 Saturday wraps to Sunday", {21'b0, dow_out}, 24'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_months();
        day_step(24'h250429); check("R5 Apr 29 to 30", date_out, 24'h250430);
        day_step(24'h250430); check("R5 Apr 30 to May 01", date_out, 24'h250501);
        day_step(24'h250930); check("R5 Sep 30 to Oct 01", date_out, 24'h251001);
        day_step(24'h250730); check("R5 Jul 30 to 31", date_out, 24'h250731);
    endtask

    task automatic t_feb();
        load_date(24'h250228);
        check("R6 year 25 not leap", {23'b0, leap_out}, 24'h0);
        day_step(24'h250228); check("R6 Feb 28 common year", date_out, 24'h250301);
        day_step(24'h240228); check("R6 Feb 28 leap year", date_out, 24'h240229);
        check("R6 year 24 leap", {23'b0, leap_out}, 24'h1);
        day_step(24'h240229); check("R6 Feb 29 leap year", date_out, 24'h240301);
        load_date(24'h120101);
        check("R6 year 12 leap", {23'b0, leap_out}, 24'h1);
    endtask

    task automatic t_year_end();
        day_step(24'h991231);
        check("R7 Dec 31 99 wraps", date_out, 24'h000101);
        check("R7 leap after wrap", {23'b0, leap_out}, 24'h1);
        day_step(24'h251231);
        check("R7 Dec 31 to Jan 01", date_out, 24'h260101);
    endtask

    task automatic t_weekday();
        load_dow(3'd3);
        day_step(24'h250310);
        check("R8 Wednesday to Thursday", {21'b0, dow_out}, 24'h4);
        load_time(24'h100000); tick_once();
        check("R8 weekday held mid-day", {21'b0, dow_out}, 24'h4);
        load_dow(3'd7);
        day_step(24'h250310);
        check("R8 reserved code wraps", {21'b0, dow_out}, 24'h0);
    endtask

    task automatic t_12h();
        hr12_sel = 1'b1;
        load_date(24'h250110);
        load_time(24'h115959); tick_once();
        check("R4 11 AM to 12 PM", time_out, 24'h320000);
        check("R4 no date step at noon", date_out, 24'h250110);
        load_time(24'h315959); tick_once();
        check("R4 11 PM to 12 AM", time_out, 24'h120000);
        check("R4 date steps at midnight", date_out, 24'h250111);
        load_time(24'h125959); tick_once();
        check("R4 12 to 01", time_out, 24'h010000);
        load_time(24'h295959); tick_once();
        check("R4 9 PM to 10 PM", time_out, 24'h300000);
        hr12_sel = 1'b0;
    endtask

    task automatic t_alarm();
        hr12_sel = 1'b0;
        load_alarm(24'h123005, 24'h240315);
        load_date(24'h240315);
        load_time(24'h123004);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R12 flag not before fourth edge", {23'b0, alm_flag}, 24'h0);
        @(negedge clk);
        check("R9 flag sets on match", {23'b0, alm_flag}, 24'h1);
        @(negedge clk);
        pulse_clear();
        check("R10 clear drops flag", {23'b0, alm_flag}, 24'h0);
        load_time(24'h123005);
        repeat (4) @(negedge clk);
        check("R9 load of matching value ignored", {23'b0, alm_flag}, 24'h0);
        load_date(24'h240316);
        load_time(24'h123004); tick_once();
        check("R9 date mismatch no flag", {23'b0, alm_flag}, 24'h0);
    endtask

    task automatic t_clear_race();
        load_date(24'h240315);
        load_time(24'h123004);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk);
        @(negedge clk); alm_clr = 1'b1;
        @(negedge clk); alm_clr = 1'b0;
        check("R10 match wins over clear", {23'b0, alm_flag}, 24'h1);
        pulse_clear();
        check("R10 later clear", {23'b0, alm_flag}, 24'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_seconds();
        t_midnight24();
        t_months();
        t_feb();
        t_year_end();
        t_weekday();
        t_12h();
        t_alarm();
        t_clear_race();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule